// File: doc/BRIEF.md
# Serial Flash Read Window

This block sits on a CPU bus as a slave and answers reads from a 16 MiB address window by fetching the bytes from an external serial flash. Every mapped read becomes one complete serial transaction on select line 0: a read opcode, a three-byte flash address and four data bytes. The bus request stalls until the transaction finishes, and the four bytes come back as one 32-bit word. The serial bus runs with the clock idling high. Data leaves on the falling edge and is captured on the rising edge.

After reset only the bottom 4 MiB of flash is reachable, and it repeats four times across the window, so a CPU that starts fetching near the top of the window still finds the start of flash. A remap-disable bit widens the mapping so that all 16 MiB pass straight through.

Software can also write a function-select location to take the window away from the flash. While mapping is off, bus accesses reach a small register bank instead, and that is where the remap-disable bit can be changed. Writing the select location again restores the mapping.

Top module: `spiwin_flash_window`

## Requirements
- R1: While select 0 is high, `spi_sck` is high. `spi_mosi` changes only in the cycle where `spi_sck` falls. The read data bits are captured from `spi_miso` at the rising edges of `spi_sck`.
- R2: Only `spi_cs_n[0]` is ever driven low; every other select bit stays high at all times.
- R3: With remap-disable clear, the flash address equals the window address with bits 23:22 forced to zero (window 0xC00100 reads flash 0x000100).
- R4: The control register sits at window offset 0x4, and bit 0 of that register is remap-disable. When this bit is set, window address bits 23:0 go to the flash unchanged. In register mode a read of offset 0x4 returns the bit in position 0 and zeros elsewhere.
- R5: Function select sits at window offset 0x0 and takes writes in either mode. Writing bit 0 = 0 routes later accesses to the register bank, and no serial activity happens while the bank is routed. Writing bit 0 = 1 restores mapped reads. In register mode, reads of offset 0x0 return zero.
- R6: A serial transaction sends opcode 0x03 first, then the 24-bit address with its most significant bit first, and then shifts in 32 data bits. The first received byte lands in `bus_rdata[31:24]` and the fourth in `bus_rdata[7:0]`.
- R7: `bus_ready` is a one-cycle pulse. For a mapped read it rises exactly 130·(CLK_DIV/2)+2 clock edges after the edge that accepts the request, so it stays low until all data bits are in. Writes and register-mode reads complete one edge after acceptance.
- R8: Select 0 rises only after the last data bit has been captured. It then stays high for at least one clock before any later transaction starts, and it is high whenever `bus_ready` is.
- R9: Inside a transaction, successive rising edges of `spi_sck` are exactly CLK_DIV system clocks apart.
- R10: Reset leaves mapping enabled, remap-disable clear, all selects high, `spi_sck` high and `bus_ready` low.
- R11: In mapped mode, writes to any offset other than 0x0 are ignored. They start no serial transaction and leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request; held high until `bus_ready` is seen |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | CS_N | Active-low selects; only bit 0 is used |

## Verification
The assertions check the line-level rules on every cycle: the clock is high while the flash is deselected, the output data changes only on falling edges, the spare selects stay high, the ready pulse lasts one cycle, and select 0 is high whenever ready is and for the cycle after it rises. Only the bench scenarios can show that the opcode and the translated address reach the flash and that the returned word has the right byte order. The same applies to the mirror and pass-through address mappings, the exact stall length and serial clock period, and the way function select and the control bit move between modes. The bench checks these against a behavioural flash model, along with the writes that must have no effect.

// File: rtl/spiwin_pkg.sv
package spiwin_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_RUN,
      ENG_TAIL,
      ENG_GAP
   } eng_state_t;

   typedef enum logic {
      BUS_IDLE,
      BUS_WAIT
   } bus_state_t;

   localparam int OFF_FSEL = 0;
   localparam int OFF_CTRL = 4;
   localparam logic [7:0] RD_OPCODE = 8'h03;

endpackage

// File: rtl/spiwin_addr_xlate.sv
module spiwin_addr_xlate #(
   parameter int ADDR_W = 24,
   parameter int BOOT_W = 22
) (
   input  logic [ADDR_W-1:0] win_addr,
   input  logic              remap_dis,
   output logic [ADDR_W-1:0] flash_addr
);

   localparam int HI_W = ADDR_W - BOOT_W;

   generate
      if (HI_W == 0) begin : g_flat
         logic unused_remap;
         assign unused_remap = remap_dis;
         assign flash_addr   = win_addr;
      end else begin : g_mirror
         assign flash_addr = remap_dis ? win_addr
                                       : {{HI_W{1'b0}}, win_addr[BOOT_W-1:0]};
      end
   endgenerate

endmodule

// File: rtl/spiwin_rd_engine.sv
module spiwin_rd_engine
   import spiwin_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic              done,
   output logic              sck,
   output logic              mosi,
   output logic              cs_n,
   input  logic              miso
);

   localparam int HALF  = CLK_DIV / 2;
   localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int HDR_W = 8 + ADDR_W;
   localparam int TOT   = HDR_W + DATA_W;
   localparam int BC_W  = $clog2(TOT + 1);

   eng_state_t        state_q;
   logic [HC_W-1:0]   hc_q;
   logic [HDR_W-1:0]  hdr_q;
   logic [DATA_W-1:0] rx_q;
   logic [BC_W-1:0]   bits_q;
   logic              sck_q, mosi_q, cs_q, done_q;
   logic              tick;

   assign tick = (hc_q == HC_W'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         hc_q    <= '0;
         hdr_q   <= '0;
         rx_q    <= '0;
         bits_q  <= '0;
         sck_q   <= 1'b1;
         mosi_q  <= 1'b0;
         cs_q    <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state_q == ENG_IDLE) begin
            if (start) begin
               cs_q    <= 1'b0;
               hc_q    <= '0;
               hdr_q   <= {RD_OPCODE, addr};
               bits_q  <= '0;
               state_q <= ENG_RUN;
            end
         end else begin
            hc_q <= tick ? '0 : hc_q + HC_W'(1);
            if (tick) begin
               case (state_q)
                  ENG_RUN: begin
                     if (sck_q) begin
                        sck_q  <= 1'b0;
                        mosi_q <= hdr_q[HDR_W-1];
                        hdr_q  <= {hdr_q[HDR_W-2:0], 1'b0};
                     end else begin
                        sck_q  <= 1'b1;
                        rx_q   <= {rx_q[DATA_W-2:0], miso};
                        bits_q <= bits_q + BC_W'(1);
                        if (bits_q == BC_W'(TOT - 1)) state_q <= ENG_TAIL;
                     end
                  end
                  ENG_TAIL: begin
                     cs_q    <= 1'b1;
                     state_q <= ENG_GAP;
                  end
                  default: begin
                     state_q <= ENG_IDLE;
                     done_q  <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

   assign data = rx_q;
   assign done = done_q;
   assign sck  = sck_q;
   assign mosi = mosi_q;
   assign cs_n = cs_q;

endmodule

// File: rtl/spiwin_flash_window.sv
module spiwin_flash_window
   import spiwin_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int ADDR_W  = 24,
   parameter int BOOT_W  = 22,
   parameter int DATA_W  = 32,
   parameter int CS_N    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [CS_N-1:0]   spi_cs_n
);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if ((ADDR_W % 8) != 0 || ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be a nonzero multiple of 8");
      end
      if (BOOT_W < 1 || BOOT_W > ADDR_W) begin : g_bad_boot
         $error("BOOT_W must lie in 1..ADDR_W");
      end
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be a nonzero multiple of 8");
      end
      if (CS_N < 1) begin : g_bad_cs
         $error("CS_N must be at least 1");
      end
   endgenerate

   bus_state_t        bstate_q;
   logic              ready_q, map_en_q, remap_dis_q;
   logic [DATA_W-1:0] rdata_q;
   logic              accept, start, is_fsel, is_ctrl;
   logic [ADDR_W-1:0] flash_addr;
   logic [DATA_W-1:0] eng_data;
   logic              eng_done, eng_cs_n;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:1];
   assign accept  = bus_req && !ready_q && (bstate_q == BUS_IDLE);
   assign start   = accept && map_en_q && !bus_we;
   assign is_fsel = (bus_addr == ADDR_W'(OFF_FSEL));
   assign is_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));

   spiwin_addr_xlate #(
      .ADDR_W(ADDR_W),
      .BOOT_W(BOOT_W)
   ) u_xlate (
      .win_addr  (bus_addr),
      .remap_dis (remap_dis_q),
      .flash_addr(flash_addr)
   );

   spiwin_rd_engine #(
      .CLK_DIV(CLK_DIV),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_engine (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .addr (flash_addr),
      .data (eng_data),
      .done (eng_done),
      .sck  (spi_sck),
      .mosi (spi_mosi),
      .cs_n (eng_cs_n),
      .miso (spi_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bstate_q    <= BUS_IDLE;
         ready_q     <= 1'b0;
         rdata_q     <= '0;
         map_en_q    <= 1'b1;
         remap_dis_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         if (bstate_q == BUS_IDLE) begin
            if (start) begin
               bstate_q <= BUS_WAIT;
            end else if (accept) begin
               ready_q <= 1'b1;
               rdata_q <= '0;
               if (bus_we) begin
                  if (is_fsel) map_en_q <= bus_wdata[0];
                  else if (is_ctrl && !map_en_q) remap_dis_q <= bus_wdata[0];
               end else if (is_ctrl) begin
                  rdata_q <= {{(DATA_W-1){1'b0}}, remap_dis_q};
               end
            end
         end else if (eng_done) begin
            ready_q  <= 1'b1;
            rdata_q  <= eng_data;
            bstate_q <= BUS_IDLE;
         end
      end
   end

   generate
      if (CS_N > 1) begin : g_spare_cs
         assign spi_cs_n = {{(CS_N-1){1'b1}}, eng_cs_n};
      end else begin : g_single_cs
         assign spi_cs_n = eng_cs_n;
      end
   endgenerate

   assign bus_ready = ready_q;
   assign bus_rdata = rdata_q;

endmodule

// File: rtl/spiwin_flash_window_chk.sv
module spiwin_flash_window_chk #(
   parameter int CS_N = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_ready,
   input logic            spi_sck,
   input logic            spi_mosi,
   input logic [CS_N-1:0] spi_cs_n
);

   AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n[0] |-> spi_sck); // R1

   AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spi_mosi) |-> $fell(spi_sck)); // R1

   AST_SELECT_WITH_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n[0]) |-> spi_sck); // R1

   generate
      if (CS_N > 1) begin : g_spare
         AST_SPARE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (&spi_cs_n[CS_N-1:1])); // R2
      end
   endgenerate

   AST_READY_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready); // R7

   AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> spi_cs_n[0]); // R8

   AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n[0]) |=> spi_cs_n[0]); // R8

endmodule

bind spiwin_flash_window spiwin_flash_window_chk #(.CS_N(CS_N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_ready(bus_ready),
   .spi_sck  (spi_sck),
   .spi_mosi (spi_mosi),
   .spi_cs_n (spi_cs_n)
);

// File: tb/spiwin_flash_window_bench.sv
`timescale 1ns/1ps
module spiwin_flash_window_bench;

   localparam int CLK_DIV = 4;
   localparam int CS_N    = 3;
   localparam int RD_CYC  = 130 * (CLK_DIV / 2) + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        spi_sck, spi_mosi;
   logic        spi_miso = 1'b0;
   logic [CS_N-1:0] spi_cs_n;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   spiwin_flash_window #(.CLK_DIV(CLK_DIV), .CS_N(CS_N)) u_spiwin_flash_window (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   function automatic logic [7:0] fbyte(logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ {a[22:16], a[23]} ^ 8'h5A;
   endfunction

   function automatic logic [31:0] fword(logic [23:0] a);
      return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
   endfunction

   // behavioural flash and line monitors
   int          nbits = 0;
   logic [31:0] shin = '0;
   logic [7:0]  got_cmd = '0;
   logic [23:0] got_addr = '0;
   logic [31:0] word_q = '0;
   realtime     last_rise = 0;
   realtime     cs_rise_t = 0;
   int          per_bad = 0;
   int          gap_bad = 0;
   int          cs_falls = 0;
   int          idle_bad = 0;
   int          spare_bad = 0;

   always @(posedge spi_sck or posedge spi_cs_n[0]) begin
      if (spi_cs_n[0]) begin
         nbits     = 0;
         cs_rise_t = $realtime;
      end else begin
         if (nbits > 0 && ($realtime - last_rise) != CLK_DIV * 4.0) per_bad++;
         last_rise = $realtime;
         if (nbits < 32) shin = {shin[30:0], spi_mosi};
         nbits++;
         if (nbits == 32) begin
            got_cmd  = shin[31:24];
            got_addr = shin[23:0];
            word_q   = fword(shin[23:0]);
         end
      end
   end

   always @(negedge spi_sck) begin
      if (!spi_cs_n[0] && nbits >= 32 && nbits < 64) spi_miso = word_q[63 - nbits];
   end

   always @(negedge spi_cs_n[0]) begin
      cs_falls++;
      if (cs_rise_t > 0 && ($realtime - cs_rise_t) < 4.0) gap_bad++;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (spi_cs_n[0] && !spi_sck) idle_bad++;
         if (spi_cs_n[CS_N-1:1] != '1) spare_bad++;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_xfer(input logic we, input logic [23:0] a, input logic [31:0] wd,
                           output logic [31:0] rd, output int cyc);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!bus_ready && cyc < 2000);
      rd = bus_rdata;
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic mapped_read(input string tag, input logic [23:0] win, input logic [23:0] fa);
      logic [31:0] rd;
      int cyc;
      int pb;
      pb = per_bad;
      bus_xfer(1'b0, win, '0, rd, cyc);
      check({tag, " R6 opcode"}, 32'(got_cmd), 32'h03);
      check({tag, " R3/R4 flash address"}, 32'(got_addr), 32'(fa));
      check({tag, " R6/R1 data word"}, rd, fword(fa));
      check({tag, " R7 stall length"}, 32'(cyc), 32'(RD_CYC));
      check({tag, " R9 sck period"}, 32'(per_bad - pb), 32'd0);
   endtask

   task automatic t_reset;
      check("R10 selects after reset", 32'(spi_cs_n), 32'h7);
      check("R10 sck after reset", 32'(spi_sck), 32'd1);
      check("R10 ready after reset", 32'(bus_ready), 32'd0);
   endtask

   task automatic t_mirror;
      mapped_read("mirror low", 24'h000100, 24'h000100);
      mapped_read("mirror top copy", 24'hC00100, 24'h000100);
      mapped_read("mirror wrap", 24'h7FFFFE, 24'h3FFFFE);
   endtask

   task automatic t_register_mode;
      logic [31:0] rd;
      int cyc;
      int falls0;
      bus_xfer(1'b1, 24'h000000, 32'h0, rd, cyc);
      check("R7 write completes in one cycle", 32'(cyc), 32'd1);
      falls0 = cs_falls;
      bus_xfer(1'b0, 24'h000004, '0, rd, cyc);
      check("R4 control reads clear", rd, 32'h0);
      check("R7 register read one cycle", 32'(cyc), 32'd1);
      bus_xfer(1'b1, 24'h000004, 32'hFFFF_FFFF, rd, cyc);
      bus_xfer(1'b0, 24'h000004, '0, rd, cyc);
      check("R4 control reads set bit", rd, 32'h1);
      bus_xfer(1'b0, 24'h000000, '0, rd, cyc);
      check("R5 select reads zero", rd, 32'h0);
      bus_xfer(1'b0, 24'h000100, '0, rd, cyc);
      check("R5 no flash access in register mode", 32'(cs_falls - falls0), 32'd0);
      bus_xfer(1'b1, 24'h000000, 32'h1, rd, cyc);
   endtask

   task automatic t_full_map;
      mapped_read("full map high", 24'hC00100, 24'hC00100);
      mapped_read("full map mid", 24'h5ABCD4, 24'h5ABCD4);
   endtask

   task automatic t_ignored_writes;
      logic [31:0] rd;
      int cyc;
      int falls0;
      falls0 = cs_falls;
      bus_xfer(1'b1, 24'h000004, 32'h0, rd, cyc);
      bus_xfer(1'b1, 24'h000100, 32'h0, rd, cyc);
      check("R11 mapped writes start no transaction", 32'(cs_falls - falls0), 32'd0);
      bus_xfer(1'b1, 24'h000000, 32'h0, rd, cyc);
      bus_xfer(1'b0, 24'h000004, '0, rd, cyc);
      check("R11 control untouched by mapped write", rd, 32'h1);
      bus_xfer(1'b1, 24'h000004, 32'h0, rd, cyc);
      bus_xfer(1'b1, 24'h000000, 32'h1, rd, cyc);
      mapped_read("mirror restored", 24'hC00010, 24'h000010);
   endtask

   task automatic t_back_to_back;
      mapped_read("back-to-back first", 24'h123450, 24'h123450);
      mapped_read("back-to-back second", 24'h123454, 24'h123454);
      check("R8 select gap", 32'(gap_bad), 32'd0);
      check("R1 clock high while deselected", 32'(idle_bad), 32'd0);
      check("R2 spare selects high", 32'(spare_bad), 32'd0);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mirror();
      t_register_mode();
      t_full_map();
      t_ignored_writes();
      t_back_to_back();
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule